// File: doc/BRIEF.md
# Prefix-Driven Effective Address Unit

This block forms the memory operand addresses for an 8-bit CPU that points at memory through 24-bit register triples. A single prefix byte may come before an instruction to change how its memory operands are addressed. The prefix can add one of the four register triples, add a displacement taken from the instruction stream, or step the pointer up or down before or after the access. The unit decodes the prefix and produces, for the source and for the destination operand, the effective address and, for the stepping modes, the new pointer value to write back into the triple.

The fetch sequencer presents one instruction's operand context with `valid_i`. This includes the prefix byte (if there is one), the base pointer of each operand, whether each operand is in memory, the four triple values, the three displacement bytes and the operand width. One clock later the unit returns the addresses, the write-back controls and the number of displacement bytes the prefix consumes. A prefix applies to every memory operand of its instruction, so a step prefix moves both pointers when both operands are in memory.

Top module: `prefix_ea_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first accepted request, every output is zero.
- R2: A request with `valid_i` high is reflected on the outputs at the next rising clock edge, with `valid_o` high for that one cycle. While `valid_i` is low, `valid_o` is low and all other outputs keep their values.
- R3: With `has_pfx_i` low, or with a prefix byte that is not one of the codes listed in R4 to R8, a memory operand's address equals its base. In that case there is no write-back and `disp_len_o` is 0.
- R4: Prefixes 8'hC0, 8'hC5, 8'hCA and 8'hCF add triple A, B, C or D respectively to the base. Triple A is `triples_i[23:0]`, B is `[47:24]`, C is `[71:48]` and D is `[95:72]`. `disp_len_o` is 0.
- R5: Prefix 8'h9B adds the first displacement byte `disp_i[7:0]`, zero-extended to 24 bits, and sets `disp_len_o` to 1.
- R6: Prefix 8'h9F adds the 24-bit little-endian displacement `disp_i`, with the first byte in `[7:0]` and the last in `[23:16]`, and sets `disp_len_o` to 3.
- R7: Prefix 8'hFC (pre-increment) gives address = write-back = base + step. Prefix 8'hFD (post-increment) gives address = base and write-back = base + step.
- R8: Prefix 8'hFE (pre-decrement) gives address = write-back = base − step. Prefix 8'hFF (post-decrement) gives address = base and write-back = base − step.
- R9: The step is 1 when `wide_i` is 0 (byte operand) and 3 when `wide_i` is 1 (24-bit load/store operand).
- R10: All address arithmetic is modulo 2^24. It wraps past 24'hFFFFFF and below 24'h000000.
- R11: The prefix applies independently to the source and the destination. An operand whose `*_mem_i` flag is 0 gets address 0, write-back value 0 and write-back enable 0.
- R12: The write-back enable is set only for a memory operand under prefixes 8'hFC to 8'hFF. When the enable is clear, the write-back value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| has_pfx_i | input | 1 | Instruction carries a prefix byte |
| prefix_i | input | 8 | Prefix byte |
| wide_i | input | 1 | Operand is 24-bit (step 3) rather than byte (step 1) |
| src_mem_i | input | 1 | Source operand is in memory |
| src_base_i | input | 24 | Source pointer triple value |
| dst_mem_i | input | 1 | Destination operand is in memory |
| dst_base_i | input | 24 | Destination pointer triple value |
| triples_i | input | 96 | Triples A..D, A in the low 24 bits |
| disp_i | input | 24 | Displacement bytes, first byte in the low 8 bits |
| valid_o | output | 1 | Result strobe |
| disp_len_o | output | 2 | Displacement bytes consumed (0, 1 or 3) |
| src_ea_o | output | 24 | Source effective address |
| src_wb_en_o | output | 1 | Source pointer write-back enable |
| src_wb_o | output | 24 | Source pointer write-back value |
| dst_ea_o | output | 24 | Destination effective address |
| dst_wb_en_o | output | 1 | Destination pointer write-back enable |
| dst_wb_o | output | 24 | Destination pointer write-back value |

## Verification
The bench drives the pointer arithmetic across the 24-bit boundary: a post-increment at 24'hFFFFFF, a pre-decrement by 3 at 24'h000001, and a 3-byte displacement that overflows. A unit that carried into a 25th bit or sign-extended the short displacement would give a wrong address there. It mixes pre and post forms so that a design that swapped them would emit the stepped pointer as the address, or emit the unstepped pointer on a pre-step. It also checks the register prefixes against their triple order, so a swapped triple index shows up as a wrong offset. Undefined prefix bytes next to the real codes (8'hC1, 8'h9C, 8'hFB) are used to catch loose decoding. Instructions with only one memory operand are used to catch a design that writes back or addresses through a register operand.

// File: rtl/eau_pkg.sv
package eau_pkg;
  typedef enum logic [2:0] {
    M_NONE,
    M_REG,
    M_D1,
    M_D3,
    M_PREINC,
    M_POSTINC,
    M_PREDEC,
    M_POSTDEC
  } mode_e;
endpackage

// File: rtl/eau_decode.sv
module eau_decode
  import eau_pkg::*;
(
  input  logic       has_pfx_i,
  input  logic [7:0] prefix_i,
  output mode_e      mode_o,
  output logic [1:0] idx_o,
  output logic [1:0] disp_len_o
);
  always_comb begin
    mode_o     = M_NONE;
    idx_o      = prefix_i[1:0];
    disp_len_o = 2'd0;
    if (has_pfx_i) begin
      // self-move codes: high nibble C, both 2-bit fields equal
      if (prefix_i[7:4] == 4'hC && prefix_i[3:2] == prefix_i[1:0]) begin
        mode_o = M_REG;
      end else if (prefix_i == 8'h9B) begin
        mode_o     = M_D1;
        disp_len_o = 2'd1;
      end else if (prefix_i == 8'h9F) begin
        mode_o     = M_D3;
        disp_len_o = 2'd3;
      end else if (prefix_i[7:2] == 6'h3F) begin
        unique case (prefix_i[1:0])
          2'b00:   mode_o = M_PREINC;
          2'b01:   mode_o = M_POSTINC;
          2'b10:   mode_o = M_PREDEC;
          default: mode_o = M_POSTDEC;
        endcase
      end
    end
  end
endmodule

// File: rtl/eau_operand.sv
module eau_operand
  import eau_pkg::*;
#(
  parameter int AW        = 24,
  parameter int BYTE_STEP = 1,
  parameter int WIDE_STEP = 3
) (
  input  logic          mem_i,
  input  logic [AW-1:0] base_i,
  input  mode_e         mode_i,
  input  logic          wide_i,
  input  logic [AW-1:0] reg_off_i,
  input  logic [AW-1:0] disp_i,
  output logic [AW-1:0] ea_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_o
);
  localparam logic [AW-1:0] STEP_B = AW'(BYTE_STEP);
  localparam logic [AW-1:0] STEP_W = AW'(WIDE_STEP);

  logic [AW-1:0] step, inc, dec, d1;

  assign step = wide_i ? STEP_W : STEP_B;
  assign inc  = base_i + step;
  assign dec  = base_i - step;
  assign d1   = {{(AW-8){1'b0}}, disp_i[7:0]};

  always_comb begin
    ea_o    = '0;
    wb_en_o = 1'b0;
    wb_o    = '0;
    if (mem_i) begin
      unique case (mode_i)
        M_REG:     ea_o = base_i + reg_off_i;
        M_D1:      ea_o = base_i + d1;
        M_D3:      ea_o = base_i + disp_i;
        M_PREINC:  begin ea_o = inc;    wb_en_o = 1'b1; wb_o = inc; end
        M_POSTINC: begin ea_o = base_i; wb_en_o = 1'b1; wb_o = inc; end
        M_PREDEC:  begin ea_o = dec;    wb_en_o = 1'b1; wb_o = dec; end
        M_POSTDEC: begin ea_o = base_i; wb_en_o = 1'b1; wb_o = dec; end
        default:   ea_o = base_i;
      endcase
    end
  end
endmodule

// File: rtl/prefix_ea_unit.sv
module prefix_ea_unit
  import eau_pkg::*;
#(
  parameter int AW        = 24,
  parameter int NTRIPLE   = 4,
  parameter int BYTE_STEP = 1,
  parameter int WIDE_STEP = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  has_pfx_i,
  input  logic [7:0]            prefix_i,
  input  logic                  wide_i,
  input  logic                  src_mem_i,
  input  logic [AW-1:0]         src_base_i,
  input  logic                  dst_mem_i,
  input  logic [AW-1:0]         dst_base_i,
  input  logic [NTRIPLE*AW-1:0] triples_i,
  input  logic [AW-1:0]         disp_i,
  output logic                  valid_o,
  output logic [1:0]            disp_len_o,
  output logic [AW-1:0]         src_ea_o,
  output logic                  src_wb_en_o,
  output logic [AW-1:0]         src_wb_o,
  output logic [AW-1:0]         dst_ea_o,
  output logic                  dst_wb_en_o,
  output logic [AW-1:0]         dst_wb_o
);
  localparam int NOPS = 2;
  localparam int IW   = $clog2(NTRIPLE);

  mode_e         mode;
  logic [1:0]    idx;
  logic [1:0]    dlen;
  logic [AW-1:0] trip [NTRIPLE];
  logic [AW-1:0] reg_off;

  eau_decode u_dec (
    .has_pfx_i (has_pfx_i),
    .prefix_i  (prefix_i),
    .mode_o    (mode),
    .idx_o     (idx),
    .disp_len_o(dlen)
  );

  for (genvar t = 0; t < NTRIPLE; t++) begin : g_trip
    assign trip[t] = triples_i[t*AW +: AW];
  end
  assign reg_off = trip[IW'(idx)];

  logic          op_mem  [NOPS];
  logic [AW-1:0] op_base [NOPS];
  logic [AW-1:0] op_ea   [NOPS];
  logic          op_wben [NOPS];
  logic [AW-1:0] op_wb   [NOPS];

  assign op_mem[0]  = src_mem_i;
  assign op_base[0] = src_base_i;
  assign op_mem[1]  = dst_mem_i;
  assign op_base[1] = dst_base_i;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    eau_operand #(
      .AW(AW), .BYTE_STEP(BYTE_STEP), .WIDE_STEP(WIDE_STEP)
    ) u_op (
      .mem_i    (op_mem[k]),
      .base_i   (op_base[k]),
      .mode_i   (mode),
      .wide_i   (wide_i),
      .reg_off_i(reg_off),
      .disp_i   (disp_i),
      .ea_o     (op_ea[k]),
      .wb_en_o  (op_wben[k]),
      .wb_o     (op_wb[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      disp_len_o  <= '0;
      src_ea_o    <= '0;
      src_wb_en_o <= 1'b0;
      src_wb_o    <= '0;
      dst_ea_o    <= '0;
      dst_wb_en_o <= 1'b0;
      dst_wb_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        disp_len_o  <= dlen;
        src_ea_o    <= op_ea[0];
        src_wb_en_o <= op_wben[0];
        src_wb_o    <= op_wb[0];
        dst_ea_o    <= op_ea[1];
        dst_wb_en_o <= op_wben[1];
        dst_wb_o    <= op_wb[1];
      end
    end
  end
endmodule

// File: rtl/eau_checker.sv
module eau_checker #(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          has_pfx_i,
  input logic [7:0]    prefix_i,
  input logic          src_mem_i,
  input logic [AW-1:0] src_base_i,
  input logic          dst_mem_i,
  input logic          valid_o,
  input logic [1:0]    disp_len_o,
  input logic [AW-1:0] src_ea_o,
  input logic          src_wb_en_o,
  input logic [AW-1:0] src_wb_o,
  input logic [AW-1:0] dst_ea_o,
  input logic          dst_wb_en_o
);
  logic started;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !started)
    valid_o == $past(valid_i));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !started)
    !$past(valid_i) |-> ($stable(src_ea_o) && $stable(dst_ea_o) && $stable(disp_len_o)));

  p_plain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !started)
    $past(valid_i && !has_pfx_i && src_mem_i) |-> (src_ea_o == $past(src_base_i) && !src_wb_en_o));

  p_postinc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !started)
    $past(valid_i && has_pfx_i && prefix_i == 8'hFD && src_mem_i)
      |-> (src_ea_o == $past(src_base_i) && src_wb_en_o));

  p_nonmem_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || !started)
    $past(valid_i && !dst_mem_i) |-> (dst_ea_o == '0 && !dst_wb_en_o));

  p_wb_only_step_r12: assert property (@(posedge clk_i) disable iff (!rst_ni || !started)
    (valid_o && src_wb_en_o) |-> $past(has_pfx_i && prefix_i[7:2] == 6'h3F));

  p_wb_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni || !started)
    !src_wb_en_o |-> (src_wb_o == '0));

  p_disp_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !started)
    disp_len_o != 2'd2);
endmodule

bind prefix_ea_unit eau_checker #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .has_pfx_i  (has_pfx_i),
  .prefix_i   (prefix_i),
  .src_mem_i  (src_mem_i),
  .src_base_i (src_base_i),
  .dst_mem_i  (dst_mem_i),
  .valid_o    (valid_o),
  .disp_len_o (disp_len_o),
  .src_ea_o   (src_ea_o),
  .src_wb_en_o(src_wb_en_o),
  .src_wb_o   (src_wb_o),
  .dst_ea_o   (dst_ea_o),
  .dst_wb_en_o(dst_wb_en_o)
);

// File: tb/prefix_ea_unit_test.sv
module prefix_ea_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic          has_pfx_i = 1'b0;
  logic [7:0]    prefix_i = '0;
  logic          wide_i = 1'b0;
  logic          src_mem_i = 1'b0;
  logic [AW-1:0] src_base_i = '0;
  logic          dst_mem_i = 1'b0;
  logic [AW-1:0] dst_base_i = '0;
  logic [4*AW-1:0] triples_i = '0;
  logic [AW-1:0] disp_i = '0;
  logic          valid_o;
  logic [1:0]    disp_len_o;
  logic [AW-1:0] src_ea_o, src_wb_o, dst_ea_o, dst_wb_o;
  logic          src_wb_en_o, dst_wb_en_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prefix_ea_unit uut (.*);

  // expected {wb_en, wb, ea} for one operand
  function automatic logic [2*AW:0] model(input logic mem, input logic [AW-1:0] base,
                                          input logic hp, input logic [7:0] p,
                                          input logic wide, input logic [4*AW-1:0] tr,
                                          input logic [AW-1:0] d);
    logic [AW-1:0] st, ea, wb;
    logic en;
    st = wide ? 24'd3 : 24'd1;
    ea = base; wb = '0; en = 1'b0;
    if (!mem) return '0;
    if (hp) begin
      case (p)
        8'hC0: ea = base + tr[23:0];
        8'hC5: ea = base + tr[47:24];
        8'hCA: ea = base + tr[71:48];
        8'hCF: ea = base + tr[95:72];
        8'h9B: ea = base + {16'h0, d[7:0]};
        8'h9F: ea = base + d;
        8'hFC: begin ea = base + st; wb = base + st; en = 1'b1; end
        8'hFD: begin wb = base + st; en = 1'b1; end
        8'hFE: begin ea = base - st; wb = base - st; en = 1'b1; end
        8'hFF: begin wb = base - st; en = 1'b1; end
        default: ;
      endcase
    end
    return {en, wb, ea};
  endfunction

  function automatic logic [1:0] model_len(input logic hp, input logic [7:0] p);
    if (!hp) return 2'd0;
    if (p == 8'h9B) return 2'd1;
    if (p == 8'h9F) return 2'd3;
    return 2'd0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request at negedge, check at the following negedge
  task automatic run(input string req, input logic hp, input logic [7:0] p, input logic wide,
                     input logic sm, input logic [AW-1:0] sb, input logic dm,
                     input logic [AW-1:0] db, input logic [4*AW-1:0] tr, input logic [AW-1:0] d);
    logic [2*AW:0] es, ed;
    @(negedge clk_i);
    valid_i = 1'b1; has_pfx_i = hp; prefix_i = p; wide_i = wide;
    src_mem_i = sm; src_base_i = sb; dst_mem_i = dm; dst_base_i = db;
    triples_i = tr; disp_i = d;
    es = model(sm, sb, hp, p, wide, tr, d);
    ed = model(dm, db, hp, p, wide, tr, d);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " valid"}, 64'(valid_o), 64'd1);
    chk({req, " len"}, 64'(disp_len_o), 64'(model_len(hp, p)));
    chk({req, " src"}, 64'({src_wb_en_o, src_wb_o, src_ea_o}), 64'(es));
    chk({req, " dst"}, 64'({dst_wb_en_o, dst_wb_o, dst_ea_o}), 64'(ed));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [4*AW-1:0] tr;
    logic [7:0] codes [14];
    logic [AW-1:0] h_ea;
    void'($urandom(32'd1234));
    codes = '{8'hC0, 8'hC5, 8'hCA, 8'hCF, 8'h9B, 8'h9F, 8'hFC, 8'hFD, 8'hFE, 8'hFF,
              8'hC1, 8'h9C, 8'hFB, 8'h00};
    tr = {24'h400000, 24'h030000, 24'h000200, 24'h000010};

    #(CLK_PERIOD * 3);
    @(negedge clk_i);
    // R1 reset state
    chk("R1 valid", 64'(valid_o), 0);
    chk("R1 outs", 64'({disp_len_o, src_ea_o, src_wb_en_o, src_wb_o}), 0);
    chk("R1 dst", 64'({dst_ea_o, dst_wb_en_o, dst_wb_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", 64'({valid_o, src_ea_o, dst_ea_o}), 0);

    // R3 no prefix, undefined codes
    run("R3 none", 1'b0, 8'hC0, 1'b0, 1'b1, 24'h123456, 1'b1, 24'h654321, tr, 24'hFFFFFF);
    run("R3 C1", 1'b1, 8'hC1, 1'b0, 1'b1, 24'h000100, 1'b1, 24'h000200, tr, 24'h0);
    run("R3 9C", 1'b1, 8'h9C, 1'b1, 1'b1, 24'h000100, 1'b0, 24'h000200, tr, 24'h55);
    run("R3 FB", 1'b1, 8'hFB, 1'b1, 1'b1, 24'h000100, 1'b1, 24'h000200, tr, 24'h55);
    // R4 each triple
    run("R4 A", 1'b1, 8'hC0, 1'b0, 1'b1, 24'h000001, 1'b0, 24'h0, tr, 24'h0);
    run("R4 B", 1'b1, 8'hC5, 1'b0, 1'b1, 24'h000001, 1'b1, 24'h000002, tr, 24'h0);
    run("R4 C", 1'b1, 8'hCA, 1'b0, 1'b0, 24'h000001, 1'b1, 24'h000002, tr, 24'h0);
    run("R4 D", 1'b1, 8'hCF, 1'b0, 1'b1, 24'h000001, 1'b1, 24'h000002, tr, 24'h0);
    // R5 zero-extension, R6 little-endian and wrap (R10)
    run("R5 zext", 1'b1, 8'h9B, 1'b0, 1'b1, 24'h001000, 1'b1, 24'h0000F0, tr, 24'hABCDF0);
    run("R6 le", 1'b1, 8'h9F, 1'b0, 1'b1, 24'h001000, 1'b0, 24'h0, tr, 24'h030201);
    run("R10 d3 wrap", 1'b1, 8'h9F, 1'b0, 1'b1, 24'hFFFF00, 1'b1, 24'h800000, tr, 24'h000200);
    // R7 R8 R9 R10 stepping
    run("R7 postinc wrap", 1'b1, 8'hFD, 1'b0, 1'b1, 24'hFFFFFF, 1'b1, 24'h000010, tr, 24'h0);
    run("R7 preinc wide", 1'b1, 8'hFC, 1'b1, 1'b1, 24'hFFFFFE, 1'b1, 24'h000010, tr, 24'h0);
    run("R8 predec wide wrap", 1'b1, 8'hFE, 1'b1, 1'b1, 24'h000001, 1'b1, 24'h000100, tr, 24'h0);
    run("R8 postdec byte", 1'b1, 8'hFF, 1'b0, 1'b1, 24'h000000, 1'b0, 24'h000100, tr, 24'h0);
    run("R9 postdec wide", 1'b1, 8'hFF, 1'b1, 1'b0, 24'h0, 1'b1, 24'h000005, tr, 24'h0);
    // R11 R12 step with register source
    run("R11 dst only", 1'b1, 8'hFC, 1'b0, 1'b0, 24'h777777, 1'b1, 24'h000020, tr, 24'h0);

    // R2 hold: change inputs with valid low
    h_ea = src_ea_o;
    @(negedge clk_i);
    src_base_i = 24'h0BADBA; has_pfx_i = 1'b0; src_mem_i = 1'b1; dst_mem_i = 1'b1;
    @(negedge clk_i);
    chk("R2 valid low", 64'(valid_o), 0);
    chk("R2 hold", 64'(src_ea_o), 64'(h_ea));

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [4*AW-1:0] rt;
      logic [7:0] p;
      rt = {$urandom, $urandom, $urandom};
      p = ($urandom % 4 == 0) ? 8'($urandom) : codes[$urandom % 14];
      run("R11 random", 1'($urandom), p, 1'($urandom), 1'($urandom), 24'($urandom),
          1'($urandom), 24'($urandom), rt, 24'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule